// File: doc/BRIEF.md
# Real-Time Clock Interrupt Controller

This block is the timing and interrupt section of a legacy-style real-time clock. A time-base enable at 32.768 kHz advances a binary prescaler. Taps of that prescaler produce a periodic interrupt whose rate is picked by a four-bit code. Two of the fastest codes are served by a separate counter that runs on the system clock. An external one-second tick opens an update-in-progress window. When the window closes, the update-ended event fires. An external alarm-match strobe raises the alarm event.

Each of the three events sets a sticky flag, whether or not its enable is set. A summary request bit is the OR of every flag gated by its enable bit, and the single IRQ output follows that summary. Software reaches four byte registers through an index/data pair. It first writes an index with the select line low, then reads or writes data with the select line high. Reading the flag register returns the flags and clears them.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the control register (index 0x0A) reads 0x20, the enable register (index 0x0B) reads 0x00, the flag register (index 0x0C) reads 0x00 and IRQ is low. Any index outside 0x0A to 0x0D reads 0x00. The index is written with select low, and data is accessed with select high.
- R2: Bit 7 of the control register is read-only and reflects update-in-progress. Bits 6:0 of the control register and all eight bits of the enable register hold what was written.
- R3: With divider bits 6:4 = 010 and rate code c in bits 3:0, for c from 3 to 15, a periodic event occurs every 2^(c-1) time-base ticks. The first event comes 2^(c-1) ticks after the divider leaves its hold state.
- R4: Rate codes 1 and 2 give a periodic event every FAST_CYC and 2*FAST_CYC system clock cycles, counted from the cycle the divider leaves hold.
- R5: Rate code 0 produces no periodic events. Divider codes 110 and 111 hold both counters cleared, and no periodic events occur while they are selected.
- R6: A one-second tick, with divider 010 and the halt bit (enable register bit 7) clear, sets control bit 7 for UIP_LEN time-base ticks. When bit 7 clears, the update flag (bit 4) sets.
- R7: While the halt bit is set, one-second ticks are ignored and control bit 7 stays clear. Setting halt during an open window closes it without setting the update flag.
- R8: An alarm-match strobe sets the alarm flag (bit 5).
- R9: Flags set independently of their enables. Flag register bit 7 and the IRQ output equal the OR of periodic flag (bit 6) AND enable bit 6, alarm flag AND enable bit 5, and update flag AND enable bit 4. Bits 3:0 of the flag register read 0. Setting an enable for a flag that is already pending raises IRQ.
- R10: A data read of the flag register returns the flags as they were, then clears them and lowers IRQ. An event in the same cycle as the read is kept and shows on the next read.
- R11: The power-status register (index 0x0D) always reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | 32.768 kHz time-base enable, one clock wide per tick |
| sec_tick | input | 1 | One-second update request strobe |
| alarm_match | input | 1 | Alarm comparison hit strobe |
| bus_sel | input | 1 | 0 = index register, 1 = data register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (data register only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
A wrong prescaler tap or fast-counter limit shows up as an IRQ edge that arrives early or late. The bench measures the IRQ edge against the exact tick count after the divider leaves hold, so the first period exposes the error. A stuck update-window counter shows as control bit 7 read back wrong within a few cycles of the tick, or as a missing update flag. A flag bank that clears at the wrong moment loses an event that lands on the read cycle, and the second flag read exposes that. Halt and enable gating errors appear on the next IRQ sample or flag read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int RATE_W = 4;
  localparam int PRE_W  = (1 << RATE_W) - 2;
  localparam int NSRC   = 3;

  localparam logic [7:0] IDX_CTRL = 8'h0A;
  localparam logic [7:0] IDX_ENAB = 8'h0B;
  localparam logic [7:0] IDX_FLAG = 8'h0C;
  localparam logic [7:0] IDX_PWR  = 8'h0D;

  localparam logic [2:0] DIV_RUN   = 3'b010;
  localparam logic [6:0] CTRL_RST  = 7'h20;
  localparam logic [7:0] PWR_VALUE = 8'h80;

  // flag bank order matches enable register bits 6:4
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;
endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_irq_pkg::*;
#(
  parameter int FAST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_en,
  input  logic [RATE_W-1:0] rate,
  input  logic [2:0]        div,
  output logic              per_ev
);
  localparam int FW = $clog2(2 * FAST_CYC);

  logic             run, hold, fast_sel;
  logic [PRE_W-1:0] pre_q;
  logic [FW-1:0]    fast_q, fast_lim;
  logic [15:0]      tap;

  assign run      = (div == DIV_RUN);
  assign hold     = (div[2:1] == 2'b11);
  assign fast_sel = (rate == 4'd1) || (rate == 4'd2);
  assign fast_lim = (rate == 4'd2) ? FW'(2 * FAST_CYC - 1) : FW'(FAST_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst || hold)        pre_q <= '0;
    else if (run && tb_en)  pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || hold || !run || !fast_sel) fast_q <= '0;
    else if (fast_q == fast_lim)          fast_q <= '0;
    else                                  fast_q <= fast_q + 1'b1;
  end

  assign tap[2:0] = 3'b000;
  for (genvar k = 3; k < 16; k++) begin : g_tap
    assign tap[k] = &pre_q[k-2:0];
  end

  assign per_ev = run && ((tb_en && (rate >= 4'd3) && tap[rate]) ||
                          (fast_sel && (fast_q == fast_lim)));

  // R4: fast counter never runs past its limit
  a_r4_fast_bound: assert property (@(posedge clk) disable iff (rst)
    fast_sel |-> (fast_q <= FW'(2 * FAST_CYC - 1)));
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int UIP_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tb_en,
  input  logic sec_tick,
  input  logic run,
  input  logic halt,
  output logic uip,
  output logic upd_ev
);
  localparam int CW = (UIP_LEN > 2) ? $clog2(UIP_LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(UIP_LEN - 1));
  assign upd_ev = uip && tb_en && last && run && !halt;

  always_ff @(posedge clk) begin
    if (rst || halt || !run) begin
      uip   <= 1'b0;
      cnt_q <= '0;
    end else if (!uip) begin
      if (sec_tick) begin
        uip   <= 1'b1;
        cnt_q <= '0;
      end
    end else if (tb_en) begin
      if (last) uip   <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: halt closes the window on the next edge
  a_r7_halt_clears: assert property (@(posedge clk) disable iff (rst)
    halt |=> !uip);
  // R6: window opens only on a tick
  a_r6_open_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> $past(sec_tick));
  // R6: update event closes the window
  a_r6_event_closes: assert property (@(posedge clk) disable iff (rst)
    upd_ev |=> !uip);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic            clr,
  input  logic [NSRC-1:0] en_next,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  logic [NSRC-1:0] flag_n;

  assign flag_n = (clr ? '0 : flags) | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flag_n;
      irq   <= |(flag_n & en_next);
    end
  end

  // R10: after a clearing read only the same-cycle events remain
  a_r10_clear_keeps_new: assert property (@(posedge clk) disable iff (rst)
    clr |=> (flags == $past(ev)));
  // R8: alarm strobe always lands in the bank
  a_r8_alarm_sets: assert property (@(posedge clk) disable iff (rst)
    ev[SRC_ALM] |=> flags[SRC_ALM]);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int FAST_CYC = 8,
  parameter int UIP_LEN  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tb_en,
  input  logic       sec_tick,
  input  logic       alarm_match,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic [7:0]      idx_q;
  logic [6:0]      ctrl_q, ctrl_n;
  logic [7:0]      enab_q, enab_n;
  logic            data_wr, data_rd, flag_rd;
  logic            uip, upd_ev, per_ev, irqf;
  logic [NSRC-1:0] ev, flags;
  logic [7:0]      rd_mux;

  assign data_wr = bus_wr && bus_sel;
  assign data_rd = bus_rd && bus_sel;
  assign flag_rd = data_rd && (idx_q == IDX_FLAG);

  assign ctrl_n = (data_wr && idx_q == IDX_CTRL) ? bus_wdata[6:0] : ctrl_q;
  assign enab_n = (data_wr && idx_q == IDX_ENAB) ? bus_wdata      : enab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      ctrl_q <= CTRL_RST;
      enab_q <= '0;
    end else begin
      if (bus_wr && !bus_sel) idx_q <= bus_wdata;
      ctrl_q <= ctrl_n;
      enab_q <= enab_n;
    end
  end

  rtc_rate_gen #(.FAST_CYC(FAST_CYC)) u_rate (
    .clk(clk), .rst(rst), .tb_en(tb_en),
    .rate(ctrl_q[3:0]), .div(ctrl_q[6:4]), .per_ev(per_ev)
  );

  rtc_update_seq #(.UIP_LEN(UIP_LEN)) u_upd (
    .clk(clk), .rst(rst), .tb_en(tb_en), .sec_tick(sec_tick),
    .run(ctrl_q[6:4] == DIV_RUN), .halt(enab_q[7]),
    .uip(uip), .upd_ev(upd_ev)
  );

  always_comb begin
    ev          = '0;
    ev[SRC_PER] = per_ev;
    ev[SRC_ALM] = alarm_match;
    ev[SRC_UPD] = upd_ev;
  end

  rtc_flag_bank u_flags (
    .clk(clk), .rst(rst), .ev(ev), .clr(flag_rd),
    .en_next(enab_n[6:4]), .flags(flags), .irq(irq)
  );

  assign irqf = |(flags & enab_q[6:4]);

  always_comb begin
    case (idx_q)
      IDX_CTRL: rd_mux = {uip, ctrl_q};
      IDX_ENAB: rd_mux = enab_q;
      IDX_FLAG: rd_mux = {irqf, flags, 4'b0000};
      IDX_PWR:  rd_mux = PWR_VALUE;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (data_rd) bus_rdata <= rd_mux;
  end

  // R9: registered IRQ tracks enabled flags
  a_r9_irq_summary: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & enab_q[6:4]));
  // R5: a held divider keeps the periodic flag quiet
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[6:5] == 2'b11 && !flags[SRC_PER]) |=> !flags[SRC_PER]);
  // R7: no update window while halted
  a_r7_no_uip_halted: assert property (@(posedge clk) disable iff (rst)
    (enab_q[7] && $past(enab_q[7])) |-> !uip);
endmodule

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst, tb_en, sec_tick, alarm_match;
  logic       bus_sel, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq;
  logic       rd_seen;
  bit         done = 1'b0;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rtc_irq_ctrl #(.FAST_CYC(3), .UIP_LEN(8)) dut (
    .clk(clk), .rst(rst), .tb_en(tb_en), .sec_tick(sec_tick),
    .alarm_match(alarm_match), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops scoreboard on each completed data read
  always @(posedge clk) rd_seen <= bus_rd && bus_sel;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read 0x%02h expected 0x%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk_bit(input string t, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] idx);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = idx;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    set_idx(idx);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = val;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] exp, input string t);
    set_idx(idx);
    exp_q.push_back(exp); tag_q.push_back(t);
    bus_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic meas(input string t, input int exp);
    int n = 0;
    while (!irq && n < 200) begin
      @(posedge clk); n++; @(negedge clk);
    end
    n_cmp++;
    if (n != exp) begin
      n_bad++;
      $display("FAIL %s: irq after %0d cycles expected %0d", t, n, exp);
    end
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_match = 1'b1;
    @(negedge clk); alarm_match = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tb_en = 1'b0; sec_tick = 1'b0; alarm_match = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk_bit("R1 irq after reset", irq, 1'b0);
    rd_reg(8'h0A, 8'h20, "R1 ctrl reset");
    rd_reg(8'h0B, 8'h00, "R1 enab reset");
    rd_reg(8'h0C, 8'h00, "R1 flag reset");
    rd_reg(8'h05, 8'h00, "R1 unmapped index");
    rd_reg(8'h0D, 8'h80, "R11 power status");

    // R2 writable fields
    wr_reg(8'h0A, 8'hA0);
    rd_reg(8'h0A, 8'h20, "R2 ctrl bit7 read-only");
    wr_reg(8'h0B, 8'h5A);
    rd_reg(8'h0B, 8'h5A, "R2 enab write");
    wr_reg(8'h0B, 8'h40);

    // R3 / R4 periodic rates from divider release
    tb_en = 1'b1;
    wr_reg(8'h0A, 8'h70);
    rd_reg(8'h0C, 8'h00, "R5 no events before release");
    wr_reg(8'h0A, 8'h23); meas("R3 code 3 period", 4);
    wr_reg(8'h0A, 8'h70); rd_reg(8'h0C, 8'hC0, "R3 code 3 flag");
    chk_bit("R10 irq low after flag read", irq, 1'b0);
    wr_reg(8'h0A, 8'h24); meas("R3 code 4 period", 8);
    wr_reg(8'h0A, 8'h70); rd_reg(8'h0C, 8'hC0, "R3 code 4 flag");
    wr_reg(8'h0A, 8'h21); meas("R4 code 1 period", 3);
    wr_reg(8'h0A, 8'h70); rd_reg(8'h0C, 8'hC0, "R4 code 1 flag");
    wr_reg(8'h0A, 8'h22); meas("R4 code 2 period", 6);
    wr_reg(8'h0A, 8'h70); rd_reg(8'h0C, 8'hC0, "R4 code 2 flag");

    // R9 flag without enable, R10 clear
    wr_reg(8'h0B, 8'h00);
    wr_reg(8'h0A, 8'h23);
    repeat (20) @(negedge clk);
    wr_reg(8'h0A, 8'h70);
    chk_bit("R9 irq low with enable off", irq, 1'b0);
    rd_reg(8'h0C, 8'h40, "R9 periodic flag without enable");
    rd_reg(8'h0C, 8'h00, "R10 flags cleared by read");

    // R5 disabled rate and held divider
    wr_reg(8'h0A, 8'h20);
    repeat (100) @(negedge clk);
    rd_reg(8'h0C, 8'h00, "R5 code 0 no events");
    wr_reg(8'h0A, 8'h73);
    repeat (100) @(negedge clk);
    rd_reg(8'h0C, 8'h00, "R5 divider hold no events");

    // R6 update window
    wr_reg(8'h0A, 8'h20);
    wr_reg(8'h0B, 8'h10);
    pulse_sec();
    rd_reg(8'h0A, 8'hA0, "R6 uip during window");
    chk_bit("R6 irq low inside window", irq, 1'b0);
    repeat (10) @(negedge clk);
    chk_bit("R6 irq after update", irq, 1'b1);
    rd_reg(8'h0A, 8'h20, "R6 uip clear after window");
    rd_reg(8'h0C, 8'h90, "R6 update flag");

    // R7 halt aborts and suppresses
    pulse_sec();
    wr_reg(8'h0B, 8'h90);
    repeat (12) @(negedge clk);
    rd_reg(8'h0C, 8'h00, "R7 aborted window no flag");
    rd_reg(8'h0B, 8'h90, "R2 halt bit readback");
    pulse_sec();
    rd_reg(8'h0A, 8'h20, "R7 no uip while halted");
    repeat (12) @(negedge clk);
    rd_reg(8'h0C, 8'h00, "R7 no update while halted");

    // R8 alarm
    wr_reg(8'h0B, 8'h20);
    pulse_alarm();
    chk_bit("R8 alarm irq", irq, 1'b1);
    rd_reg(8'h0C, 8'hA0, "R8 alarm flag with enable");
    wr_reg(8'h0B, 8'h00);
    pulse_alarm();
    chk_bit("R9 alarm irq gated off", irq, 1'b0);
    wr_reg(8'h0B, 8'h20);
    chk_bit("R9 late enable raises irq", irq, 1'b1);
    rd_reg(8'h0C, 8'hA0, "R9 late enable flag");

    // R10 event during the clearing read survives
    wr_reg(8'h0B, 8'h00);
    set_idx(8'h0C);
    exp_q.push_back(8'h00); tag_q.push_back("R10 read coincident with alarm");
    bus_sel = 1'b1; bus_rd = 1'b1; alarm_match = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_sel = 1'b0; alarm_match = 1'b0;
    @(negedge clk);
    rd_reg(8'h0C, 8'h20, "R10 coincident alarm kept");

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule